// File: doc/BRIEF.md
# Buffered SPI Slave with Host Byte Port

This block is an SPI slave that runs entirely on the system clock. The serial clock, data-in and select lines are brought into the system clock domain through synchroniser chains, and edges of the serial clock are detected there. The block shifts bytes in from the master and out to the master, most significant bit first. It uses SPI mode 0: incoming data is sampled on the rising serial clock edge and outgoing data changes on the falling edge. Because of the synchronisers, the serial clock must run slower than a quarter of the system clock.

A host sees a byte-wide port. A write lands in a transmit holding buffer, which feeds the shift register. If the shift register is empty, the byte moves across on the next cycle. If the shift register is busy, the byte moves when the byte in flight completes. A read returns the receive buffer, and the read strobe marks that buffer as free.

Three sticky flags record events for the host: byte done, write collision and receive overrun. They drive an interrupt line that an enable input gates. A two-bit select-mode input chooses between two wirings. In 4-wire wiring, the select line enables the slave and realigns byte framing. In 3-wire wiring, the select line is ignored and only toggling the module enable realigns framing.

Top module: `spi_target_buffered`

## Requirements
- R1: After 8 rising serial-clock edges while the slave is active, the assembled byte (first bit received in bit 7) is offered to the receive buffer and `flag_done` is set.
- R2: `miso` presents bit 7 of the shift register before the first rising edge and advances one bit per falling edge, so the master reads the loaded byte most significant bit first. A byte sent while no data was loaded reads as 0x00.
- R3: A host write into an empty holding buffer moves to the shift register one cycle later when the shift register is empty. Otherwise it moves at the completion of the byte in flight and is sent in the following byte.
- R4: A host write while the holding buffer is still occupied is discarded, the held byte is kept, and `flag_wcol` is set.
- R5: When a byte completes while the receive buffer is full and not being read in that cycle, the new byte is dropped, `rd_data` keeps the old byte, and `flag_ovr` is set.
- R6: `rd_data` shows the receive buffer, and a cycle with `rd_en` high frees it for the next byte.
- R7: `ss_mode` = 00 selects 3-wire wiring, and any other value (01 is the intended code) selects 4-wire wiring. In 4-wire wiring, serial-clock edges are ignored while `nss` is high, and a falling edge on `nss` clears the bit counter.
- R8: In 3-wire wiring `nss` is ignored. The bit counter keeps counting across `nss` changes and is cleared only while `enable` is low.
- R9: `miso_oe` is high only while `enable` is high and either 3-wire wiring is selected or `nss` is low.
- R10: Each flag stays set until its clear input is pulsed. A set event in the same cycle as a clear wins.
- R11: `irq` is high exactly when `irq_en` is high and at least one flag is set.
- R12: After reset, all flags are low, the receive and holding buffers are empty, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| nss | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the external tri-state pad driver of miso |
| enable | input | 1 | Module enable; low clears the bit counter and empties the shift register |
| ss_mode | input | 2 | Select wiring: 00 three-wire, otherwise four-wire |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Host write strobe into the holding buffer |
| wr_data | input | DATA_W | Host write data |
| rd_en | input | 1 | Host read strobe, frees the receive buffer |
| rd_data | output | DATA_W | Receive buffer contents |
| clr_done | input | 1 | Clears the byte-done flag |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_ovr | input | 1 | Clears the receive-overrun flag |
| flag_done | output | 1 | Sticky byte-done flag |
| flag_wcol | output | 1 | Sticky write-collision flag |
| flag_ovr | output | 1 | Sticky receive-overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit word, most-significant-first order and a two-stage synchroniser. These values make every byte a short 8-pulse sequence, so back-to-back transfers fit within the run. They also let the bench reach the holding-buffer handover at byte completion, a collision against a held byte and an overrun against an unread byte. The 8-bit count places the counter-realignment cases within reach: three stray pulses followed by a select-line fall in 4-wire wiring, and stray pulses that run into the next byte in 3-wire wiring until the enable is toggled.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

   typedef enum logic [1:0] {
      SEL_THREE_WIRE = 2'b00,
      SEL_FOUR_WIRE  = 2'b01
   } sel_mode_e;

   function automatic logic is_three_wire(input logic [1:0] mode);
      return mode == SEL_THREE_WIRE;
   endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic mosi_i,
   input  logic nss_i,
   output logic sck_rise,
   output logic sck_fall,
   output logic nss_fall,
   output logic mosi_s,
   output logic nss_s
);
   localparam int NSIG = 3;
   localparam logic [NSIG-1:0] RST_VAL = 3'b100;

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] synced;
   logic [NSIG-1:0] delayed;

   assign raw = {nss_i, mosi_i, sck_i};

   for (genvar g = 0; g < NSIG; g++) begin : g_chain
      logic [STAGES-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL[g]}};
            delayed[g] <= RST_VAL[g];
         end else begin
            stage_q <= {stage_q[STAGES-2:0], raw[g]};
            delayed[g] <= stage_q[STAGES-1];
         end
      end
      assign synced[g] = stage_q[STAGES-1];
   end

   assign sck_rise = synced[0] & ~delayed[0];
   assign sck_fall = ~synced[0] & delayed[0];
   assign mosi_s   = synced[1];
   assign nss_s    = synced[2];
   assign nss_fall = ~synced[2] & delayed[2];

endmodule

// File: rtl/spi_tgt_shifter.sv
module spi_tgt_shifter #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              active,
   input  logic              cnt_clr,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              mosi_s,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              out_bit,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              sh_full
);
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sreg;
   logic [DATA_W-1:0] shifted;
   logic [CNT_W-1:0]  cnt;
   logic              samp;
   logic              edge_ok;

   if (MSB_FIRST) begin : g_msb
      assign out_bit = sreg[DATA_W-1];
      assign shifted = {sreg[DATA_W-2:0], samp};
      assign rx_byte = {sreg[DATA_W-2:0], mosi_s};
   end else begin : g_lsb
      assign out_bit = sreg[0];
      assign shifted = {samp, sreg[DATA_W-1:1]};
      assign rx_byte = {mosi_s, sreg[DATA_W-1:1]};
   end

   assign edge_ok   = run & active & ~cnt_clr;
   assign byte_done = edge_ok & sck_rise & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         sreg    <= '0;
         samp    <= 1'b0;
         sh_full <= 1'b0;
      end else if (!run) begin
         cnt     <= '0;
         sreg    <= '0;
         samp    <= 1'b0;
         sh_full <= 1'b0;
      end else begin
         if (cnt_clr) begin
            cnt <= '0;
         end else if (active && sck_rise) begin
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
            samp <= mosi_s;
         end
         if (edge_ok && sck_fall && cnt != '0) begin
            sreg <= shifted;
         end
         if (load) begin
            sreg    <= load_data;
            sh_full <= 1'b1;
         end else if (byte_done) begin
            sreg    <= '0;
            sh_full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              clr_done,
   input  logic              clr_wcol,
   input  logic              clr_ovr,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              sh_full,
   output logic              load,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_full,
   output logic              flag_done,
   output logic              flag_wcol,
   output logic              flag_ovr
);
   logic rx_open;

   assign load    = run & hold_valid & (~sh_full | byte_done);
   assign rx_open = ~rx_full | rd_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data  <= '0;
         hold_valid <= 1'b0;
         flag_wcol  <= 1'b0;
      end else begin
         if (clr_wcol) flag_wcol <= 1'b0;
         if (load) hold_valid <= 1'b0;
         if (wr_en) begin
            if (hold_valid) begin
               flag_wcol <= 1'b1;
            end else begin
               hold_data  <= wr_data;
               hold_valid <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         rx_full   <= 1'b0;
         flag_done <= 1'b0;
         flag_ovr  <= 1'b0;
      end else begin
         if (clr_done) flag_done <= 1'b0;
         if (clr_ovr)  flag_ovr  <= 1'b0;
         if (rd_en)    rx_full   <= 1'b0;
         if (byte_done) begin
            flag_done <= 1'b1;
            if (rx_open) begin
               rd_data <= rx_byte;
               rx_full <= 1'b1;
            end else begin
               flag_ovr <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spi_target_buffered.sv
module spi_target_buffered #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              mosi,
   input  logic              nss,
   output logic              miso,
   output logic              miso_oe,
   input  logic              enable,
   input  logic [1:0]        ss_mode,
   input  logic              irq_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              clr_done,
   input  logic              clr_wcol,
   input  logic              clr_ovr,
   output logic              flag_done,
   output logic              flag_wcol,
   output logic              flag_ovr,
   output logic              irq
);
   import spi_tgt_pkg::*;

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              sck_rise, sck_fall, nss_fall, mosi_s, nss_s;
   logic              three_wire, active, cnt_clr;
   logic              load, hold_valid, sh_full, byte_done, rx_full, out_bit;
   logic [DATA_W-1:0] hold_data, rx_byte;

   assign three_wire = is_three_wire(ss_mode);
   assign active     = enable & (three_wire | ~nss_s);
   assign cnt_clr    = ~three_wire & nss_fall;

   spi_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .sck_i(sck), .mosi_i(mosi), .nss_i(nss),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .nss_fall(nss_fall),
      .mosi_s(mosi_s), .nss_s(nss_s)
   );

   spi_tgt_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) shift_i (
      .clk(clk), .rst_n(rst_n),
      .run(enable), .active(active), .cnt_clr(cnt_clr),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
      .load(load), .load_data(hold_data),
      .out_bit(out_bit), .byte_done(byte_done),
      .rx_byte(rx_byte), .sh_full(sh_full)
   );

   spi_tgt_regs #(.DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .run(enable),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .clr_done(clr_done), .clr_wcol(clr_wcol), .clr_ovr(clr_ovr),
      .byte_done(byte_done), .rx_byte(rx_byte), .sh_full(sh_full),
      .load(load), .hold_data(hold_data), .hold_valid(hold_valid),
      .rd_data(rd_data), .rx_full(rx_full),
      .flag_done(flag_done), .flag_wcol(flag_wcol), .flag_ovr(flag_ovr)
   );

   assign miso_oe = active;
   assign miso    = active & out_bit;
   assign irq     = irq_en & (flag_done | flag_wcol | flag_ovr);

endmodule

// File: rtl/spi_tgt_chk.sv
module spi_tgt_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              irq_en,
   input logic              irq,
   input logic              miso_oe,
   input logic              wr_en,
   input logic              rd_en,
   input logic              clr_done,
   input logic              flag_done,
   input logic              flag_wcol,
   input logic              flag_ovr,
   input logic [DATA_W-1:0] rd_data,
   input logic              hold_valid,
   input logic              sh_full,
   input logic              byte_done,
   input logic              rx_full
);
   // R1
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> flag_done);

   // R3
   hold_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable && hold_valid && !sh_full |=> !hold_valid);

   // R4
   wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && hold_valid |=> flag_wcol && hold_valid || flag_wcol && sh_full);

   // R5
   ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done && rx_full && !rd_en |=> flag_ovr && $stable(rd_data));

   // R9
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !miso_oe);

   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_done && !clr_done |=> flag_done);

   // R11
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   // R11
   irq_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en && (flag_done || flag_wcol || flag_ovr) |-> irq);

endmodule

bind spi_target_buffered spi_tgt_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .enable(enable), .irq_en(irq_en), .irq(irq),
   .miso_oe(miso_oe), .wr_en(wr_en), .rd_en(rd_en), .clr_done(clr_done),
   .flag_done(flag_done), .flag_wcol(flag_wcol), .flag_ovr(flag_ovr),
   .rd_data(rd_data), .hold_valid(hold_valid), .sh_full(sh_full),
   .byte_done(byte_done), .rx_full(rx_full)
);

// File: tb/spi_target_buffered_tb.sv
module spi_target_buffered_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, mosi = 1'b0, nss = 1'b1;
   logic       miso, miso_oe;
   logic       enable = 1'b0;
   logic [1:0] ss_mode = 2'b01;
   logic       irq_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       clr_done = 1'b0, clr_wcol = 1'b0, clr_ovr = 1'b0;
   logic       flag_done, flag_wcol, flag_ovr, irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [7:0] exp_q[$];
   logic       prev_done = 1'b0;

   always #2 clk = ~clk;

   spi_target_buffered dut_i (
      .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .nss(nss),
      .miso(miso), .miso_oe(miso_oe), .enable(enable), .ss_mode(ss_mode),
      .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .clr_done(clr_done), .clr_wcol(clr_wcol),
      .clr_ovr(clr_ovr), .flag_done(flag_done), .flag_wcol(flag_wcol),
      .flag_ovr(flag_ovr), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: on each rising byte-done flag, compare the receive buffer
   always @(negedge clk) begin
      if (rst_n && flag_done && !prev_done) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected byte", int'(rd_data), 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rd_data == e, "R1/R5 receive buffer", int'(rd_data), int'(e));
         end
      end
      prev_done <= flag_done;
   end

   task automatic one_bit(input logic b, output logic m);
      mosi = b;
      wait_clk(4);
      m = miso;
      sck = 1'b1;
      wait_clk(8);
      sck = 1'b0;
      wait_clk(4);
   endtask

   task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_rd, output logic [7:0] mi);
      exp_q.push_back(exp_rd);
      for (int i = 7; i >= 0; i--) begin
         logic m;
         one_bit(mo[i], m);
         mi[i] = m;
      end
      wait_clk(2);
   endtask

   task automatic host_write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic host_read();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk); clr_done = 1'b1; clr_wcol = 1'b1; clr_ovr = 1'b1;
      @(negedge clk); clr_done = 1'b0; clr_wcol = 1'b0; clr_ovr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] mi;
      logic       m;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(2);
      // R12 reset state
      chk(!flag_done && !flag_wcol && !flag_ovr, "R12 flags", {flag_done, flag_wcol, flag_ovr}, 0);
      chk(!irq, "R12 irq", irq, 0);
      // R9 disabled
      chk(!miso_oe, "R9 oe while disabled", miso_oe, 0);

      // 4-wire basic byte
      enable = 1'b1; ss_mode = 2'b01; irq_en = 1'b1; nss = 1'b0;
      wait_clk(4);
      chk(miso_oe, "R9 oe when selected", miso_oe, 1);
      host_write(8'hA5);
      xfer(8'h3C, 8'h3C, mi);
      chk(mi == 8'hA5, "R2 miso byte", mi, 8'hA5);
      chk(flag_done, "R1 done flag", flag_done, 1);
      chk(irq, "R11 irq on done", irq, 1);
      host_read();
      clear_all();
      chk(!flag_done && !irq, "R10 clear done", flag_done, 0);

      // R3 double buffering, R4 collision
      host_write(8'h11);
      host_write(8'h22);
      host_write(8'h33);
      chk(flag_wcol, "R4 wcol set", flag_wcol, 1);
      xfer(8'h01, 8'h01, mi);
      chk(mi == 8'h11, "R3 immediate load", mi, 8'h11);
      host_read();
      clear_all();
      xfer(8'h02, 8'h02, mi);
      chk(mi == 8'h22, "R3/R4 held byte sent, collided dropped", mi, 8'h22);
      host_read();
      clear_all();

      // R5 overrun, R2 empty shifter sends zeros
      xfer(8'h55, 8'h55, mi);
      chk(mi == 8'h00, "R2 empty sends zeros", mi, 0);
      @(negedge clk); clr_done = 1'b1; @(negedge clk); clr_done = 1'b0;
      xfer(8'h66, 8'h55, mi);
      chk(flag_ovr, "R5 overrun flag", flag_ovr, 1);
      chk(rd_data == 8'h55, "R5 old byte kept", rd_data, 8'h55);
      // R10 set-held, R11 mask
      irq_en = 1'b0;
      @(negedge clk);
      chk(!irq, "R11 irq masked", irq, 0);
      chk(flag_ovr, "R10 flag sticky", flag_ovr, 1);
      irq_en = 1'b1;
      host_read();
      clear_all();
      chk(!flag_ovr && !flag_done && !flag_wcol, "R10 cleared", {flag_done, flag_wcol, flag_ovr}, 0);

      // R6 read frees buffer
      xfer(8'h77, 8'h77, mi);
      host_read();
      clear_all();

      // R7 nss high: edges ignored
      nss = 1'b1;
      wait_clk(4);
      chk(!miso_oe, "R9 oe off with nss high", miso_oe, 0);
      for (int i = 0; i < 8; i++) one_bit(1'b1, m);
      chk(!flag_done, "R7 edges ignored while deselected", flag_done, 0);
      // R7 partial then nss fall realigns
      nss = 1'b0; wait_clk(4);
      for (int i = 0; i < 3; i++) one_bit(1'b1, m);
      nss = 1'b1; wait_clk(4);
      nss = 1'b0; wait_clk(4);
      xfer(8'h9A, 8'h9A, mi);
      chk(flag_done, "R7 aligned after nss fall", flag_done, 1);
      host_read();
      clear_all();

      // R8 three-wire: nss ignored
      ss_mode = 2'b00; nss = 1'b1;
      wait_clk(4);
      chk(miso_oe, "R8 oe in 3-wire with nss high", miso_oe, 1);
      xfer(8'hC3, 8'hC3, mi);
      host_read();
      clear_all();
      // R8 counter not reset by nss: 3 stray + 5 pulses complete a byte
      exp_q.push_back(8'hEA);
      for (int i = 0; i < 3; i++) one_bit(1'b1, m);
      nss = 1'b0; wait_clk(4); nss = 1'b1; wait_clk(4);
      one_bit(1'b0, m); one_bit(1'b1, m); one_bit(1'b0, m);
      one_bit(1'b1, m); one_bit(1'b0, m);
      wait_clk(2);
      chk(flag_done, "R8 counter kept across nss", flag_done, 1);
      host_read();
      clear_all();
      // R8 enable toggle realigns
      for (int i = 0; i < 3; i++) one_bit(1'b1, m);
      enable = 1'b0; wait_clk(3); enable = 1'b1; wait_clk(3);
      xfer(8'h5A, 8'h5A, mi);
      chk(flag_done, "R8 aligned after enable toggle", flag_done, 1);
      host_read();
      clear_all();

      wait_clk(4);
      chk(exp_q.size() == 0, "R1 all bytes seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule